// File: doc/BRIEF.md
# Conditional configuration download sequencer

This block replays a stored configuration program into a device register file. It reads a byte stream from a nonvolatile memory through a request/valid read port. It decodes each byte as an instruction and turns data records into single-byte register writes. Other instructions raise an I/O-update pulse or a calibrate pulse, manage a board of condition tags, mark a boundary between stored setups, or end the program. Because records are gated by tags, one memory image can hold several device setups, and a 5-bit condition value picks which of them gets applied.

The condition value comes from two places. When reset is released, the block samples five mode pins and runs a download straight away. Later, while the block is at rest, a `start` pulse runs a download on demand using the `sel_cond` field. Each data record is collected in a local buffer and checked against its trailing checksum before any of its bytes are written. A mismatch, an undefined opcode, or running off the end of memory stops the block with `error` set.

The controller has seven states:
- BOOT is entered from reset. It samples the mode pins, clears the tags and moves to FETCH.
- FETCH issues a read. It moves to WAIT, or to FAULT if the pointer is past the last byte.
- WAIT waits for read data. An opcode byte moves it to EXEC. An address or payload byte moves it back to FETCH. A checksum byte moves it to COMMIT on a match, to FAULT on a mismatch, or to FETCH when the record is skipped.
- EXEC decodes the opcode. It moves to FETCH, or to DONE on an end opcode, or to FAULT on an undefined opcode.
- COMMIT writes one buffered byte per cycle, then returns to FETCH.
- DONE and FAULT are rest states. A `start` pulse moves either of them to FETCH.

Top module: `cfg_replay_seq`

## Requirements
- R1: When reset is released, the block samples `mode_pins` as the selected condition and runs a download from memory address 0 without any start pulse. `busy` stays high until the block reaches a rest state.
- R2: A `start` pulse in a rest state latches `sel_cond`, clears the tag board, clears `done` and `error`, and restarts reading at address 0. A `start` pulse while `busy` is high has no effect.
- R3: Opcodes 0x00 to 0x7F are data records with N = opcode + 1 bytes. The record is laid out in memory as: opcode, register address high byte, register address low byte, N payload bytes, checksum byte. When the record runs, payload byte i is written to address + i, one write per cycle, in ascending order.
- R4: The checksum is the 8-bit sum of the opcode, both address bytes and all payload bytes. If a running record's checksum does not match, the block sets `error`, stops, and writes none of that record's bytes.
- R5: Opcodes 0xB1 to 0xCF each add the condition (opcode − 0xB0), a value from 1 to 31, to the tag board. Tags accumulate. While the board is not empty, an instruction runs only if the selected condition is one of the tags.
- R6: Opcode 0xB0 empties the tag board. While the board is empty, every instruction runs whatever the selected condition is.
- R7: A data record that is gated off still consumes all N+4 bytes. It produces no register write, and its checksum is not checked.
- R8: Opcode 0x80 produces a one-cycle `io_update` pulse and opcode 0xA0 produces a one-cycle `calib` pulse. Each pulse happens only when the tag board lets the instruction run.
- R9: Opcode 0xFE does nothing and reading continues. Opcode 0xFF ends the download: `done` goes high and `busy` goes low. Neither opcode is affected by the tags.
- R10: Any other opcode (0x81–0x9F, 0xA1–0xAF, 0xD0–0xFD) sets `error` and stops the block, whatever the tags.
- R11: If the block needs a byte beyond the last memory address (2047) without having met 0xFF, it sets `error` and stops without issuing that read.
- R12: Each memory read is a one-cycle `mem_rd` pulse with `mem_addr`, followed by a wait for `mem_valid`. The read addresses of one download go up by one from 0, with no gaps and no repeats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; release starts the automatic download |
| start | input | 1 | On-demand download request, honoured only in a rest state |
| sel_cond | input | 5 | Condition used by an on-demand download |
| mode_pins | input | 5 | Condition sampled when reset is released |
| mem_rd | output | 1 | Memory read request pulse |
| mem_addr | output | 11 | Memory byte address |
| mem_data | input | 8 | Memory read data |
| mem_valid | input | 1 | Memory read data valid |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | 16 | Register write address |
| reg_data | output | 8 | Register write data |
| io_update | output | 1 | I/O-update pulse |
| calib | output | 1 | Calibrate pulse |
| busy | output | 1 | Download in progress |
| done | output | 1 | Download ended at an end opcode |
| error | output | 1 | Download stopped on a checksum, opcode or overrun fault |

## Verification
A wrong tag board shows up at the ports within one record of the tag change. A record is then written when it should have been skipped, or skipped when it should have been written, or an `io_update` or `calib` pulse is missing or extra. A wrong pointer or a wrong record-length count shows up at once: the read addresses break their strictly ascending order, and the following bytes are decoded out of step, which usually ends in a fault within a few instructions. A bad checksum path shows up when a corrupted record is written, or when a clean record ends in `error`.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    localparam int BYTE_W   = 8;
    localparam int REG_AW   = 16;
    localparam int REC_MAX  = 128;
    localparam int REC_IW   = $clog2(REC_MAX);

    localparam logic [7:0] OP_IOUPD = 8'h80;
    localparam logic [7:0] OP_CAL   = 8'hA0;
    localparam logic [7:0] OP_CLR   = 8'hB0;
    localparam logic [7:0] OP_TAGLO = 8'hB1;
    localparam logic [7:0] OP_TAGHI = 8'hCF;
    localparam logic [7:0] OP_PAUSE = 8'hFE;
    localparam logic [7:0] OP_END   = 8'hFF;

    typedef enum logic [2:0] {
        ST_BOOT, ST_FETCH, ST_WAIT, ST_EXEC, ST_COMMIT, ST_DONE, ST_FAULT
    } seq_state_t;

    typedef enum logic [2:0] {
        BK_OP, BK_AHI, BK_ALO, BK_PAY, BK_SUM
    } byte_kind_t;

    typedef enum logic [2:0] {
        OC_DATA, OC_IOUPD, OC_CAL, OC_CLR, OC_TAG, OC_PAUSE, OC_END, OC_BAD
    } op_class_t;

    function automatic op_class_t op_classify(input logic [7:0] op);
        if (!op[7])                                 return OC_DATA;
        else if (op == OP_IOUPD)                    return OC_IOUPD;
        else if (op == OP_CAL)                      return OC_CAL;
        else if (op == OP_CLR)                      return OC_CLR;
        else if (op >= OP_TAGLO && op <= OP_TAGHI)  return OC_TAG;
        else if (op == OP_PAUSE)                    return OC_PAUSE;
        else if (op == OP_END)                      return OC_END;
        else                                        return OC_BAD;
    endfunction

endpackage

// File: rtl/cfg_seq_tagboard.sv
module cfg_seq_tagboard #(
    parameter int COND_W = 5,
    localparam int NTAG  = 1 << COND_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              set_en,
    input  logic [COND_W-1:0] set_val,
    input  logic [COND_W-1:0] sel,
    output logic              match
);
    logic [NTAG-1:0] tag_vec;

    // Condition 0 can never be tagged.
    assign tag_vec[0] = 1'b0;

    generate
        for (genvar g = 1; g < NTAG; g++) begin : g_tag
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (clr)
                    bit_q <= 1'b0;
                else if (set_en && set_val == COND_W'(g))
                    bit_q <= 1'b1;
            end
            assign tag_vec[g] = bit_q;
        end
    endgenerate

    // An empty board lets everything through.
    assign match = (tag_vec == '0) || tag_vec[sel];

endmodule

// File: rtl/cfg_seq_recbuf.sv
module cfg_seq_recbuf #(
    parameter int DEPTH = 128,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    input  logic          sum_load,
    input  logic [7:0]    sum_init,
    input  logic          sum_add,
    input  logic [7:0]    sum_byte,
    output logic          sum_ok
);
    logic [7:0] store_q [DEPTH];
    logic [7:0] sum_q;

    always_ff @(posedge clk) begin
        if (wr_en)
            store_q[wr_idx] <= wr_data;
    end

    assign rd_data = store_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sum_q <= '0;
        else if (sum_load)
            sum_q <= sum_init;
        else if (sum_add)
            sum_q <= sum_q + sum_byte;
    end

    assign sum_ok = (sum_q == sum_byte);

endmodule

// File: rtl/cfg_replay_seq.sv
module cfg_replay_seq
    import cfg_seq_pkg::*;
#(
    parameter int MEM_BYTES = 2048,
    parameter int COND_W    = 5,
    localparam int MA_W     = $clog2(MEM_BYTES),
    localparam int PTR_W    = MA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [COND_W-1:0] sel_cond,
    input  logic [COND_W-1:0] mode_pins,
    output logic              mem_rd,
    output logic [MA_W-1:0]   mem_addr,
    input  logic [7:0]        mem_data,
    input  logic              mem_valid,
    output logic              reg_we,
    output logic [REG_AW-1:0] reg_addr,
    output logic [7:0]        reg_data,
    output logic              io_update,
    output logic              calib,
    output logic              busy,
    output logic              done,
    output logic              error
);
    seq_state_t          state_q, state_d;
    byte_kind_t          kind_q;
    logic [PTR_W-1:0]    ptr_q;
    logic [7:0]          op_q;
    logic [COND_W-1:0]   cond_q;
    logic [REG_AW-1:0]   raddr_q;
    logic [REC_IW-1:0]   cnt_q;
    logic [REC_IW-1:0]   idx_q;
    logic                run_q;

    op_class_t           op_cls;
    logic                ptr_end;
    logic                at_rest;
    logic                rest_start;
    logic                byte_in;
    logic                cond_hit;
    logic                tag_clr;
    logic                tag_set;
    logic [COND_W-1:0]   tag_val;
    logic                buf_wr;
    logic                sum_add;
    logic                sum_ok;
    logic [7:0]          buf_byte;

    assign op_cls     = op_classify(op_q);
    assign ptr_end    = (ptr_q == PTR_W'(MEM_BYTES));
    assign at_rest    = (state_q == ST_DONE) || (state_q == ST_FAULT);
    assign rest_start = start && at_rest;
    assign byte_in    = (state_q == ST_WAIT) && mem_valid;

    assign tag_clr = (state_q == ST_BOOT) || rest_start ||
                     ((state_q == ST_EXEC) && (op_cls == OC_CLR));
    assign tag_set = (state_q == ST_EXEC) && (op_cls == OC_TAG);
    assign tag_val = COND_W'(op_q - OP_CLR);
    assign buf_wr  = byte_in && (kind_q == BK_PAY);
    assign sum_add = byte_in && (kind_q == BK_AHI || kind_q == BK_ALO || kind_q == BK_PAY);

    cfg_seq_tagboard #(.COND_W(COND_W)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tag_clr),
        .set_en  (tag_set),
        .set_val (tag_val),
        .sel     (cond_q),
        .match   (cond_hit)
    );

    cfg_seq_recbuf #(.DEPTH(REC_MAX)) u_rec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (buf_wr),
        .wr_idx   (idx_q),
        .wr_data  (mem_data),
        .rd_idx   (idx_q),
        .rd_data  (buf_byte),
        .sum_load (state_q == ST_EXEC),
        .sum_init (op_q),
        .sum_add  (sum_add),
        .sum_byte (mem_data),
        .sum_ok   (sum_ok)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_BOOT;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  state_d = ST_FETCH;
            ST_FETCH: state_d = ptr_end ? ST_FAULT : ST_WAIT;
            ST_WAIT: begin
                if (mem_valid) begin
                    unique case (kind_q)
                        BK_OP:   state_d = ST_EXEC;
                        BK_SUM:  state_d = !run_q ? ST_FETCH
                                          : (sum_ok ? ST_COMMIT : ST_FAULT);
                        default: state_d = ST_FETCH;
                    endcase
                end
            end
            ST_EXEC: begin
                unique case (op_cls)
                    OC_END:  state_d = ST_DONE;
                    OC_BAD:  state_d = ST_FAULT;
                    default: state_d = ST_FETCH;
                endcase
            end
            ST_COMMIT: if (idx_q == cnt_q) state_d = ST_FETCH;
            ST_DONE:   if (start) state_d = ST_FETCH;
            ST_FAULT:  if (start) state_d = ST_FETCH;
            default:   state_d = ST_FAULT;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= BK_OP;
            ptr_q   <= '0;
            op_q    <= '0;
            cond_q  <= '0;
            raddr_q <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            run_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_BOOT: begin
                    cond_q <= mode_pins;
                    ptr_q  <= '0;
                    kind_q <= BK_OP;
                end
                ST_FETCH: begin
                    if (!ptr_end)
                        ptr_q <= ptr_q + 1'b1;
                end
                ST_WAIT: begin
                    if (mem_valid) begin
                        unique case (kind_q)
                            BK_OP:  op_q <= mem_data;
                            BK_AHI: begin
                                raddr_q[15:8] <= mem_data;
                                kind_q        <= BK_ALO;
                            end
                            BK_ALO: begin
                                raddr_q[7:0] <= mem_data;
                                kind_q       <= BK_PAY;
                                idx_q        <= '0;
                            end
                            BK_PAY: begin
                                idx_q <= idx_q + 1'b1;
                                if (idx_q == cnt_q)
                                    kind_q <= BK_SUM;
                            end
                            BK_SUM: begin
                                kind_q <= BK_OP;
                                idx_q  <= '0;
                            end
                            default: kind_q <= BK_OP;
                        endcase
                    end
                end
                ST_EXEC: begin
                    if (op_cls == OC_DATA) begin
                        cnt_q  <= op_q[REC_IW-1:0];
                        run_q  <= cond_hit;
                        kind_q <= BK_AHI;
                    end
                end
                ST_COMMIT: idx_q <= idx_q + 1'b1;
                ST_DONE, ST_FAULT: begin
                    if (start) begin
                        cond_q <= sel_cond;
                        ptr_q  <= '0;
                        kind_q <= BK_OP;
                    end
                end
                default: kind_q <= BK_OP;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_rd    = 1'b0;
        reg_we    = 1'b0;
        io_update = 1'b0;
        calib     = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        error     = 1'b0;
        unique case (state_q)
            ST_FETCH:  mem_rd = !ptr_end;
            ST_EXEC: begin
                io_update = (op_cls == OC_IOUPD) && cond_hit;
                calib     = (op_cls == OC_CAL) && cond_hit;
            end
            ST_COMMIT: reg_we = 1'b1;
            ST_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            ST_FAULT: begin
                busy  = 1'b0;
                error = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_addr = ptr_q[MA_W-1:0];
    assign reg_addr = raddr_q + REG_AW'(idx_q);
    assign reg_data = buf_byte;

endmodule

// File: rtl/cfg_replay_seq_chk.sv
module cfg_replay_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        mem_rd,
    input logic        reg_we,
    input logic [15:0] reg_addr,
    input logic        io_update,
    input logic        calib,
    input logic        busy,
    input logic        done,
    input logic        error
);
    p_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!error && !busy));

    p_write_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> busy);

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && $past(reg_we)) |-> (reg_addr == $past(reg_addr) + 16'd1));

    p_rd_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    p_io_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        io_update |=> !io_update);

    p_cal_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        calib |=> !calib);

    p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);

    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_quiet_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!reg_we && !mem_rd && !io_update && !calib));

endmodule

bind cfg_replay_seq cfg_replay_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_rd    (mem_rd),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .io_update (io_update),
    .calib     (calib),
    .busy      (busy),
    .done      (done),
    .error     (error)
);

// File: tb/cfg_replay_seq_tb.sv
module cfg_replay_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MEMN       = 2048;
    localparam int WAIT_LIM   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  sel_cond = '0;
    logic [4:0]  mode_pins = '0;
    logic        mem_rd;
    logic [10:0] mem_addr;
    logic [7:0]  mem_data = '0;
    logic        mem_valid = 1'b0;
    logic        reg_we;
    logic [15:0] reg_addr;
    logic [7:0]  reg_data;
    logic        io_update, calib, busy, done, error;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_replay_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sel_cond(sel_cond),
        .mode_pins(mode_pins), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_valid(mem_valid), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_data(reg_data), .io_update(io_update),
        .calib(calib), .busy(busy), .done(done), .error(error)
    );

    logic [7:0] mem [MEMN];
    int wp;

    always @(posedge clk) begin
        mem_valid <= mem_rd;
        mem_data  <= mem[mem_addr];
    end

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [15:0] la [256]; logic [7:0] ld [256];
    logic [15:0] ea [256]; logic [7:0] ed [256];
    int nw, ne, n_io, n_cal, n_rd, rd_bad, rd_next;

    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                if (nw < 256) begin la[nw] = reg_addr; ld[nw] = reg_data; end
                nw++;
            end
            if (io_update) n_io++;
            if (calib) n_cal++;
            if (mem_rd) begin
                if (int'(mem_addr) != rd_next) rd_bad++;
                rd_next++;
                n_rd++;
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clr_log();
        nw = 0; ne = 0; n_io = 0; n_cal = 0; n_rd = 0; rd_bad = 0; rd_next = 0;
    endtask

    function automatic logic [7:0] pay(input logic [7:0] base, input int i);
        return base + 8'(i * 37);
    endfunction

    task automatic fill(input logic [7:0] v);
        for (int i = 0; i < MEMN; i++) mem[i] = v;
        wp = 0;
    endtask

    task automatic put(input logic [7:0] b);
        mem[wp] = b; wp++;
    endtask

    task automatic put_rec(input logic [15:0] a, input int n, input logic [7:0] base, input bit bad);
        logic [7:0] s;
        s = 8'(n - 1) + a[15:8] + a[7:0];
        put(8'(n - 1)); put(a[15:8]); put(a[7:0]);
        for (int i = 0; i < n; i++) begin put(pay(base, i)); s = s + pay(base, i); end
        put(bad ? s + 8'd1 : s);
    endtask

    task automatic exp_rec(input logic [15:0] a, input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            ea[ne] = a + 16'(i); ed[ne] = pay(base, i); ne++;
        end
    endtask

    task automatic cmp_writes(input string req);
        int bad_i = -1;
        if (nw == ne)
            for (int i = 0; i < ne; i++)
                if (bad_i < 0 && (la[i] != ea[i] || ld[i] != ed[i])) bad_i = i;
        chk(nw == ne, req, "write count", nw, ne);
        if (nw == ne)
            chk(bad_i < 0, req, "write address/data (first bad index)", bad_i, -1);
    endtask

    task automatic wait_end();
        int k = 0;
        while (!(done || error) && k < WAIT_LIM) begin @(negedge clk); k++; end
        if (k >= WAIT_LIM) chk(1'b0, "WD", "run timeout", k, WAIT_LIM);
    endtask

    task automatic run(input logic [4:0] c);
        @(negedge clk);
        clr_log();
        sel_cond = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end();
    endtask

    // Image with several tagged setups
    task automatic img_setups();
        fill(8'hFF);
        put_rec(16'h1000, 2, 8'h11, 1'b0);
        put(8'hB1); put(8'hB2);
        put_rec(16'h2000, 3, 8'h40, 1'b0);
        put(8'hB0); put(8'hB5); put(8'h80); put(8'hA0); put(8'hB0);
        put(8'hCF);
        put_rec(16'h3000, 1, 8'h77, 1'b0);
        put(8'hB0); put(8'hFE); put(8'h80); put(8'hFF);
    endtask

    task automatic exp_setups(input int c);
        ne = 0;
        exp_rec(16'h1000, 2, 8'h11);
        if (c == 1 || c == 2) exp_rec(16'h2000, 3, 8'h40);
        if (c == 31) exp_rec(16'h3000, 1, 8'h77);
    endtask

    initial begin
        clr_log();
        img_setups();
        mode_pins = 5'd2;
        repeat (3) @(negedge clk);
        // Reset state
        chk(!done && !error && !reg_we && !mem_rd && !io_update && !calib, "R1",
            "outputs quiet in reset", int'({done, error, reg_we, mem_rd}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R1", "busy right after reset release", busy, 1);
        wait_end();
        exp_setups(2);
        chk(done && !busy && !error, "R1", "boot run done", int'({done, busy, error}), 4);
        cmp_writes("R1");
        chk(n_io == 1 && n_cal == 0, "R8", "boot pulses io*10+cal", n_io * 10 + n_cal, 10);
        chk(n_rd == wp && rd_bad == 0, "R12", "boot read count", n_rd + rd_bad * 1000, wp);

        // Checksum mismatch on a running record
        fill(8'hFF);
        put_rec(16'h4000, 1, 8'h21, 1'b0);
        put_rec(16'h4100, 2, 8'h55, 1'b1);
        put(8'hFF);
        run(5'd0);
        ne = 0; exp_rec(16'h4000, 1, 8'h21);
        chk(error && !done, "R4", "error after bad checksum", error, 1);
        cmp_writes("R4");

        // Sweep all conditions over the setups image (first run leaves FAULT: R2)
        img_setups();
        for (int c = 0; c < 32; c++) begin
            run(5'(c));
            exp_setups(c);
            chk(done && !error, "R2", "restart ends done", int'({done, error}), 2);
            if (c == 1 || c == 2) cmp_writes("R5");
            else if (c == 31) cmp_writes("R6");
            else cmp_writes("R7");
            chk(n_io == 1 + (c == 5 ? 1 : 0), "R8", "io_update count", n_io, 1 + (c == 5 ? 1 : 0));
            chk(n_cal == (c == 5 ? 1 : 0), "R8", "calib count", n_cal, (c == 5 ? 1 : 0));
            chk(n_rd == wp && rd_bad == 0, "R12", "read sequence", n_rd + rd_bad * 1000, wp);
        end

        // Start while busy is ignored
        @(negedge clk);
        clr_log();
        sel_cond = 5'd1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        sel_cond = 5'd31; start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_end();
        exp_setups(1);
        cmp_writes("R2");
        chk(n_rd == wp && rd_bad == 0, "R2", "no restart of reads", n_rd + rd_bad * 1000, wp);

        // Skipped record with bad checksum is not checked
        fill(8'hFF);
        put(8'hB3);
        put_rec(16'h4800, 2, 8'h09, 1'b1);
        put(8'hB0);
        put_rec(16'h5000, 1, 8'hA5, 1'b0);
        put(8'hFF);
        run(5'd4);
        ne = 0; exp_rec(16'h5000, 1, 8'hA5);
        chk(done && !error, "R7", "skipped bad record no error", int'({done, error}), 2);
        cmp_writes("R7");
        chk(n_rd == wp && rd_bad == 0, "R7", "skipped record bytes read", n_rd + rd_bad * 1000, wp);

        // Largest record
        fill(8'hFF);
        put_rec(16'h6000, 128, 8'h03, 1'b0);
        put(8'hFF);
        run(5'd9);
        ne = 0; exp_rec(16'h6000, 128, 8'h03);
        chk(done && !error, "R3", "128-byte record done", int'({done, error}), 2);
        cmp_writes("R3");

        // Every non-data opcode alone followed by an end
        for (int op = 128; op < 256; op++) begin
            bit ok_op;
            fill(8'hFF);
            put(8'(op)); put(8'hFF);
            run(5'd0);
            ok_op = (op == 8'h80) || (op == 8'hA0) || (op >= 8'hB0 && op <= 8'hCF) ||
                    (op == 8'hFE) || (op == 8'hFF);
            chk(error == !ok_op && done == ok_op, ok_op ? "R9" : "R10",
                $sformatf("opcode 0x%0h error flag", op), error, !ok_op);
            chk(n_io == (op == 8'h80 ? 1 : 0) && n_cal == (op == 8'hA0 ? 1 : 0), "R8",
                $sformatf("opcode 0x%0h pulses io*10+cal", op), n_io * 10 + n_cal,
                (op == 8'h80 ? 10 : 0) + (op == 8'hA0 ? 1 : 0));
        end

        // Undefined opcode after a valid one stops further actions
        fill(8'hFF);
        put(8'h80); put(8'h9C); put(8'h80); put(8'hFF);
        run(5'd0);
        chk(error && n_io == 1, "R10", "stop at undefined opcode io count", n_io, 1);

        // Running off the end of memory
        fill(8'hFE);
        run(5'd0);
        chk(error && !done, "R11", "overrun error", error, 1);
        chk(n_rd == MEMN && rd_bad == 0, "R11", "reads before overrun", n_rd + rd_bad * 1000, MEMN);

        summary();
        $finish;
    end
endmodule